// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block takes one 64-bit instruction word and splits it between two execution slots: a memory slot and an integer slot. Two format bits decide how the word is handled. Bit 63 is the top bit of the upper half and bit 31 is the top bit of the lower half. The word can be one long instruction that uses both slots together, a parallel pair with one half on each slot, or two short instructions that run one after the other in either order.

The sequencer drives a strobe and an operation for each slot. It then waits for each slot to report completion. A completion report carries a jump flag, a jump target and a kill flag.

In the two sequential orders, the first instruction commits before the second one issues. A jump or a kill from the first instruction cancels the second. In parallel mode both halves issue in the same cycle and commit together once both have reported. The next PC is taken from whichever slot jumped, and a jump from both slots raises a fault.

At the end of every word the block gives a single completion pulse, together with a next-PC valid flag and the next-PC value.

Top module: `dual_slot_issue`

## Requirements
- R1: After reset, `in_ready` is 1. `mem_go`, `int_go`, `iss_long`, `iss_any`, `commit`, `seq_done`, `npc_vld` and `fault` are all 0.
- R2: The format code is {`in_word[63]`, `in_word[31]`}. Code 11 is a long instruction. One cycle after the word is accepted, `mem_go`, `int_go` and `iss_long` are all 1, and `mem_op`/`int_op` hold `in_word[63:32]`/`in_word[31:0]`. The mem-slot report then ends the word: `commit` and `seq_done` are 1 in the same cycle, and `npc` and `npc_vld` come from that report.
- R3: Code 01 (left then right): the first issue is `mem_go` alone, with `mem_op` = `in_word[63:32]` and `iss_any` = 0.
- R4: Code 10 (right then left): the first issue is `int_go` alone, with `int_op` = `in_word[31:0]` and `iss_any` = 0.
- R5: In a sequential order, the first slot's report raises `commit` for one cycle. The second half issues in the next cycle on the other slot, with `iss_any` = 1 and without `commit`. The other slot's report then raises `commit` and `seq_done` together, with the next PC taken from that report.
- R6: If the first sequential instruction reports a jump or a kill, the second is never issued. `seq_done` rises one cycle after `commit`. `npc_vld` equals the first instruction's jump flag and `npc` equals its target.
- R7: Code 00 (parallel): `mem_go` and `int_go` are both 1 in the same cycle, with `iss_long` = 0. The two reports may arrive in any cycles. There is exactly one `commit` with `seq_done`, in the cycle after the later report.
- R8: In parallel mode, `npc` is the target of the slot that jumped. If neither slot jumped, `npc_vld` is 0.
- R9: If both parallel slots jump, `fault` pulses together with `seq_done`, and `npc_vld` is 0.
- R10: `in_ready` is 0 from acceptance until the cycle in which `seq_done` is 1. While busy, `in_valid` is ignored and the issued operations are unchanged.
- R11: A slot report that the current state is not waiting for has no effect. This covers reports while idle and reports from the wrong slot in a sequential order.
- R12: The kill flag is cleared at the start and at the end of each word. A kill in one word never cancels the second half of a later word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_word | input | 64 | Instruction word |
| in_ready | output | 1 | Sequencer idle, word accepted when valid |
| mem_go | output | 1 | Memory-slot issue strobe |
| mem_op | output | 32 | Operation for the memory slot |
| int_go | output | 1 | Integer-slot issue strobe |
| int_op | output | 32 | Operation for the integer slot |
| iss_long | output | 1 | Issue is one long instruction spanning both slots |
| iss_any | output | 1 | Issued op is a second sequential op, any unit allowed |
| mem_done | input | 1 | Memory slot finished its op |
| mem_jmp | input | 1 | Memory slot produced a jump |
| mem_tgt | input | 32 | Memory slot jump target |
| mem_kill | input | 1 | Memory slot asks to cancel the following op |
| int_done | input | 1 | Integer slot finished its op |
| int_jmp | input | 1 | Integer slot produced a jump |
| int_tgt | input | 32 | Integer slot jump target |
| int_kill | input | 1 | Integer slot asks to cancel the following op |
| commit | output | 1 | Results of the finished op(s) commit this cycle |
| seq_done | output | 1 | Word complete pulse |
| npc_vld | output | 1 | Word produced a next-PC |
| npc | output | 32 | Next-PC value |
| fault | output | 1 | Both parallel slots jumped |

## Verification
A stale format register or a wrong state would send a half to the wrong slot. This shows on `mem_go`/`int_go`/`iss_any` in the cycle right after acceptance, or in the cycle after the first commit. A kill flag that was not cleared would show up one word later, as a second half that never issues. A fault in the parallel merge shows on `npc`, `npc_vld` or `fault` in the very cycle of `seq_done`. The bench therefore samples each of these cycles directly, rather than only the final next-PC.

// File: rtl/issue_pkg.sv
package issue_pkg;
  typedef enum logic [1:0] {
    FMT_PAR  = 2'b00,
    FMT_LR   = 2'b01,
    FMT_RL   = 2'b10,
    FMT_LONG = 2'b11
  } fmt_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT1 = 2'd1,
    ST_ISS2  = 2'd2,
    ST_WAIT2 = 2'd3
  } st_t;
endpackage

// File: rtl/fmt_decode.sv
module fmt_decode
  import issue_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic [2*HALF_W-1:0] word,
  output fmt_t                fmt,
  output logic [HALF_W-1:0]   hi,
  output logic [HALF_W-1:0]   lo
);
  localparam int HI_TOP = 2*HALF_W - 1;
  localparam int LO_TOP = HALF_W - 1;

  always_comb begin
    hi  = word[HI_TOP:HALF_W];
    lo  = word[LO_TOP:0];
    fmt = fmt_t'({word[HI_TOP], word[LO_TOP]});
  end
endmodule

// File: rtl/npc_merge.sv
module npc_merge #(
  parameter int ADDR_W = 32
) (
  input  logic              a_jmp,
  input  logic [ADDR_W-1:0] a_tgt,
  input  logic              b_jmp,
  input  logic [ADDR_W-1:0] b_tgt,
  output logic              vld,
  output logic [ADDR_W-1:0] npc,
  output logic              clash
);
  always_comb begin
    clash = a_jmp & b_jmp;
    vld   = (a_jmp ^ b_jmp);
    npc   = a_jmp ? a_tgt : b_tgt;
    if (clash) npc = '0;
  end
endmodule

// File: rtl/dual_slot_issue.sv
module dual_slot_issue
  import issue_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2*HALF_W-1:0] in_word,
  output logic                in_ready,
  output logic                mem_go,
  output logic [HALF_W-1:0]   mem_op,
  output logic                int_go,
  output logic [HALF_W-1:0]   int_op,
  output logic                iss_long,
  output logic                iss_any,
  input  logic                mem_done,
  input  logic                mem_jmp,
  input  logic [ADDR_W-1:0]   mem_tgt,
  input  logic                mem_kill,
  input  logic                int_done,
  input  logic                int_jmp,
  input  logic [ADDR_W-1:0]   int_tgt,
  input  logic                int_kill,
  output logic                commit,
  output logic                seq_done,
  output logic                npc_vld,
  output logic [ADDR_W-1:0]   npc,
  output logic                fault
);
  st_t               state;
  fmt_t              fmt_q;
  fmt_t              fmt_d;
  logic [HALF_W-1:0] hi_d, lo_d;

  logic              m_got, i_got;
  logic              m_jmp_q, i_jmp_q;
  logic [ADDR_W-1:0] m_tgt_q, i_tgt_q;
  logic              kill_q;
  logic              j1_q;
  logic [ADDR_W-1:0] t1_q;

  logic              m_jmp_n, i_jmp_n;
  logic [ADDR_W-1:0] m_tgt_n, i_tgt_n;
  logic              both_in;
  logic              mrg_vld, mrg_clash;
  logic [ADDR_W-1:0] mrg_npc;

  logic              first_lr;
  logic              f_done, f_jmp, f_kill;
  logic [ADDR_W-1:0] f_tgt;
  logic              s_done, s_jmp;
  logic [ADDR_W-1:0] s_tgt;

  fmt_decode #(.HALF_W(HALF_W)) u_dec (
    .word (in_word),
    .fmt  (fmt_d),
    .hi   (hi_d),
    .lo   (lo_d)
  );

  always_comb begin
    m_jmp_n = mem_done ? mem_jmp : m_jmp_q;
    m_tgt_n = mem_done ? mem_tgt : m_tgt_q;
    i_jmp_n = int_done ? int_jmp : i_jmp_q;
    i_tgt_n = int_done ? int_tgt : i_tgt_q;
    both_in = (m_got | mem_done) & (i_got | int_done);
  end

  npc_merge #(.ADDR_W(ADDR_W)) u_merge (
    .a_jmp (m_jmp_n),
    .a_tgt (m_tgt_n),
    .b_jmp (i_jmp_n),
    .b_tgt (i_tgt_n),
    .vld   (mrg_vld),
    .npc   (mrg_npc),
    .clash (mrg_clash)
  );

  always_comb begin
    first_lr = (fmt_q == FMT_LR);
    f_done   = first_lr ? mem_done : int_done;
    f_jmp    = first_lr ? mem_jmp  : int_jmp;
    f_tgt    = first_lr ? mem_tgt  : int_tgt;
    f_kill   = first_lr ? mem_kill : int_kill;
    s_done   = first_lr ? int_done : mem_done;
    s_jmp    = first_lr ? int_jmp  : mem_jmp;
    s_tgt    = first_lr ? int_tgt  : mem_tgt;
  end

  assign in_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      fmt_q    <= FMT_PAR;
      mem_go   <= 1'b0;
      int_go   <= 1'b0;
      mem_op   <= '0;
      int_op   <= '0;
      iss_long <= 1'b0;
      iss_any  <= 1'b0;
      commit   <= 1'b0;
      seq_done <= 1'b0;
      npc_vld  <= 1'b0;
      npc      <= '0;
      fault    <= 1'b0;
      m_got    <= 1'b0;
      i_got    <= 1'b0;
      m_jmp_q  <= 1'b0;
      i_jmp_q  <= 1'b0;
      m_tgt_q  <= '0;
      i_tgt_q  <= '0;
      kill_q   <= 1'b0;
      j1_q     <= 1'b0;
      t1_q     <= '0;
    end else begin
      mem_go   <= 1'b0;
      int_go   <= 1'b0;
      iss_long <= 1'b0;
      iss_any  <= 1'b0;
      commit   <= 1'b0;
      seq_done <= 1'b0;
      fault    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            fmt_q   <= fmt_d;
            mem_op  <= hi_d;
            int_op  <= lo_d;
            m_got   <= 1'b0;
            i_got   <= 1'b0;
            m_jmp_q <= 1'b0;
            i_jmp_q <= 1'b0;
            kill_q  <= 1'b0;
            j1_q    <= 1'b0;
            state   <= ST_WAIT1;
            case (fmt_d)
              FMT_LONG: begin
                mem_go   <= 1'b1;
                int_go   <= 1'b1;
                iss_long <= 1'b1;
              end
              FMT_PAR: begin
                mem_go <= 1'b1;
                int_go <= 1'b1;
              end
              FMT_LR:  mem_go <= 1'b1;
              default: int_go <= 1'b1;
            endcase
          end
        end
        ST_WAIT1: begin
          case (fmt_q)
            FMT_LONG: begin
              if (mem_done) begin
                commit   <= 1'b1;
                seq_done <= 1'b1;
                npc_vld  <= mem_jmp;
                npc      <= mem_tgt;
                kill_q   <= 1'b0;
                state    <= ST_IDLE;
              end
            end
            FMT_PAR: begin
              if (mem_done) begin
                m_got   <= 1'b1;
                m_jmp_q <= mem_jmp;
                m_tgt_q <= mem_tgt;
              end
              if (int_done) begin
                i_got   <= 1'b1;
                i_jmp_q <= int_jmp;
                i_tgt_q <= int_tgt;
              end
              if (both_in) begin
                commit   <= 1'b1;
                seq_done <= 1'b1;
                npc_vld  <= mrg_vld;
                npc      <= mrg_npc;
                fault    <= mrg_clash;
                kill_q   <= 1'b0;
                state    <= ST_IDLE;
              end
            end
            default: begin
              if (f_done) begin
                commit <= 1'b1;
                j1_q   <= f_jmp;
                t1_q   <= f_tgt;
                kill_q <= f_kill;
                state  <= ST_ISS2;
              end
            end
          endcase
        end
        ST_ISS2: begin
          if (j1_q || kill_q) begin
            seq_done <= 1'b1;
            npc_vld  <= j1_q;
            npc      <= t1_q;
            kill_q   <= 1'b0;
            state    <= ST_IDLE;
          end else begin
            iss_any <= 1'b1;
            if (first_lr) int_go <= 1'b1;
            else          mem_go <= 1'b1;
            state <= ST_WAIT2;
          end
        end
        default: begin
          if (s_done) begin
            commit   <= 1'b1;
            seq_done <= 1'b1;
            npc_vld  <= s_jmp;
            npc      <= s_tgt;
            kill_q   <= 1'b0;
            state    <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dual_slot_issue_chk.sv
module dual_slot_issue_chk (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic mem_go,
  input logic int_go,
  input logic iss_long,
  input logic iss_any,
  input logic commit,
  input logic seq_done,
  input logic npc_vld,
  input logic fault
);
  a_r2_long_both_slots: assert property (@(posedge clk) disable iff (rst)
    iss_long |-> (mem_go && int_go && !iss_any));

  a_r5_second_after_commit: assert property (@(posedge clk) disable iff (rst)
    iss_any |-> ($past(commit) && !commit && $onehot0({mem_go, int_go}) && (mem_go || int_go)));

  a_r5_no_issue_with_commit: assert property (@(posedge clk) disable iff (rst)
    commit |-> !(mem_go || int_go));

  a_r6_done_near_commit: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (commit || $past(commit)));

  a_r9_fault_no_npc: assert property (@(posedge clk) disable iff (rst)
    fault |-> (seq_done && !npc_vld));

  a_r10_busy_on_issue: assert property (@(posedge clk) disable iff (rst)
    (mem_go || int_go) |-> !in_ready);

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);
endmodule

bind dual_slot_issue dual_slot_issue_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .mem_go   (mem_go),
  .int_go   (int_go),
  .iss_long (iss_long),
  .iss_any  (iss_any),
  .commit   (commit),
  .seq_done (seq_done),
  .npc_vld  (npc_vld),
  .fault    (fault)
);

// File: tb/test_dual_slot_issue.sv
module test_dual_slot_issue;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic        in_ready, mem_go, int_go, iss_long, iss_any;
  logic [31:0] mem_op, int_op;
  logic        mem_done = 1'b0, mem_jmp = 1'b0, mem_kill = 1'b0;
  logic [31:0] mem_tgt = '0;
  logic        int_done = 1'b0, int_jmp = 1'b0, int_kill = 1'b0;
  logic [31:0] int_tgt = '0;
  logic        commit, seq_done, npc_vld, fault;
  logic [31:0] npc;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_slot_issue i_dual_slot_issue (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .mem_go(mem_go), .mem_op(mem_op), .int_go(int_go), .int_op(int_op),
    .iss_long(iss_long), .iss_any(iss_any),
    .mem_done(mem_done), .mem_jmp(mem_jmp), .mem_tgt(mem_tgt), .mem_kill(mem_kill),
    .int_done(int_done), .int_jmp(int_jmp), .int_tgt(int_tgt), .int_kill(int_kill),
    .commit(commit), .seq_done(seq_done), .npc_vld(npc_vld), .npc(npc), .fault(fault)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] mk(input logic f0, input logic f1,
                                     input logic [30:0] h, input logic [30:0] l);
    return {f0, h, f1, l};
  endfunction

  task automatic accept(input logic [63:0] w);
    in_valid = 1'b1;
    in_word  = w;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic rep(input logic md, input logic mj, input logic [31:0] mt, input logic mk_,
                     input logic id, input logic ij, input logic [31:0] it, input logic ik);
    mem_done = md; mem_jmp = mj; mem_tgt = mt; mem_kill = mk_;
    int_done = id; int_jmp = ij; int_tgt = it; int_kill = ik;
    tick();
    mem_done = 0; mem_jmp = 0; mem_tgt = '0; mem_kill = 0;
    int_done = 0; int_jmp = 0; int_tgt = '0; int_kill = 0;
  endtask

  task automatic t_reset();
    chk("R1 ready", in_ready, 1);
    chk("R1 strobes", {mem_go, int_go, iss_long, iss_any}, 0);
    chk("R1 outputs", {commit, seq_done, npc_vld, fault}, 0);
  endtask

  task automatic t_idle_stray();
    rep(1, 1, 32'h77, 1, 1, 1, 32'h78, 1);
    chk("R11 idle report ignored", {commit, seq_done, in_ready}, 3'b001);
  endtask

  task automatic t_long();
    logic [63:0] w = mk(1, 1, 31'h1234, 31'h5678);
    accept(w);
    chk("R2 long strobes", {mem_go, int_go, iss_long, iss_any}, 4'b1110);
    chk("R2 long ops", {mem_op, int_op}, w);
    chk("R10 busy", in_ready, 0);
    rep(1, 1, 32'h100, 0, 0, 0, 0, 0);
    chk("R2 long finish", {commit, seq_done, npc_vld}, 3'b111);
    chk("R2 long npc", npc, 32'h100);
  endtask

  task automatic t_rl_kill();
    logic [63:0] w = mk(1, 0, 31'h0aa, 31'h0bb);
    accept(w);
    chk("R4 rl first", {mem_go, int_go, iss_any}, 3'b010);
    chk("R4 rl op", int_op, w[31:0]);
    rep(0, 0, 0, 0, 1, 0, 0, 1);
    chk("R6 kill commit", {commit, seq_done}, 2'b10);
    tick();
    chk("R6 kill squash", {mem_go, int_go, seq_done, npc_vld}, 4'b0010);
    tick();
    chk("R6 kill no late issue", {mem_go, int_go, in_ready}, 3'b001);
  endtask

  task automatic t_lr();
    logic [63:0] w = mk(0, 1, 31'h0c0, 31'h0d0);
    accept(w);
    chk("R3 lr first", {mem_go, int_go, iss_any}, 3'b100);
    chk("R3 lr op", mem_op, w[63:32]);
    rep(0, 0, 0, 0, 1, 1, 32'h55, 1);
    chk("R11 wrong slot ignored", {commit, seq_done}, 0);
    in_valid = 1'b1; in_word = mk(1, 1, 31'h7fff, 31'h7fff);
    tick();
    in_valid = 1'b0;
    chk("R10 busy ignores word", {in_ready, mem_op}, {1'b0, w[63:32]});
    rep(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 lr commit", {commit, int_go, seq_done}, 3'b100);
    tick();
    chk("R12 second not killed", {int_go, mem_go, iss_any, commit}, 4'b1010);
    chk("R5 lr second op", int_op, w[31:0]);
    rep(0, 0, 0, 0, 1, 1, 32'h200, 0);
    chk("R5 lr finish", {commit, seq_done, npc_vld}, 3'b111);
    chk("R5 lr npc", npc, 32'h200);
  endtask

  task automatic t_rl();
    logic [63:0] w = mk(1, 0, 31'h111, 31'h222);
    accept(w);
    rep(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R5 rl commit", commit, 1);
    tick();
    chk("R5 rl second", {mem_go, int_go, iss_any}, 3'b101);
    chk("R5 rl second op", mem_op, w[63:32]);
    rep(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 rl finish", {commit, seq_done, npc_vld}, 3'b110);
  endtask

  task automatic t_lr_jump();
    accept(mk(0, 1, 31'h3, 31'h4));
    rep(1, 1, 32'h300, 0, 0, 0, 0, 0);
    chk("R6 jump commit", {commit, seq_done}, 2'b10);
    tick();
    chk("R6 jump squash", {int_go, seq_done, npc_vld}, 3'b011);
    chk("R6 jump npc", npc, 32'h300);
  endtask

  task automatic t_par();
    logic [63:0] w = mk(0, 0, 31'h9, 31'ha);
    accept(w);
    chk("R7 par strobes", {mem_go, int_go, iss_long, iss_any}, 4'b1100);
    rep(1, 1, 32'h400, 0, 0, 0, 0, 0);
    chk("R7 par waits", {commit, seq_done}, 0);
    tick();
    chk("R7 par still waits", {commit, seq_done}, 0);
    rep(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 par single commit", {commit, seq_done, fault}, 3'b110);
    chk("R8 mem jump npc", {npc_vld, npc}, {1'b1, 32'h400});
    tick();
    chk("R7 no second commit", {commit, seq_done}, 0);
  endtask

  task automatic t_par_int();
    accept(mk(0, 0, 31'h1, 31'h2));
    rep(1, 0, 0, 0, 1, 1, 32'h500, 0);
    chk("R8 int jump npc", {seq_done, npc_vld, npc}, {2'b11, 32'h500});
    accept(mk(0, 0, 31'h1, 31'h2));
    rep(1, 0, 0, 0, 1, 0, 0, 0);
    chk("R8 no jump", {seq_done, npc_vld, fault}, 3'b100);
  endtask

  task automatic t_par_clash();
    accept(mk(0, 0, 31'h5, 31'h6));
    rep(1, 1, 32'h600, 0, 1, 1, 32'h700, 0);
    chk("R9 fault", {seq_done, fault, npc_vld}, 3'b110);
    tick();
    chk("R9 fault pulse", fault, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_idle_stray();
    t_long();
    t_rl_kill();
    t_lr();
    t_rl();
    t_lr_jump();
    t_par();
    t_par_int();
    t_par_clash();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule